// File: doc/BRIEF.md
# Blit Scanline Address Generator

This block produces the byte addresses that a 2D blit engine reads from and writes to. A small register file holds a source and a destination scanline stride, a base address for each side, a linear start address for each side and a control word. The control word selects the pixel depth (1, 2 or 4 bytes) and the traversal direction. Writing an X/Y coordinate word loads the matching linear register with the pixel address it names: Y times the stride, plus X scaled to bytes, plus the base.

A blit is launched with a width and a height in pixels. The block then emits one source/destination address pair per pixel over a valid/ready handshake, in row-major order. It moves by one pixel size within a row and by one stride between rows. Forward blits start at the top-left pixel and run left to right, top to bottom. Backward blits start at the bottom-right pixel and run right to left, bottom to top. A one-cycle done pulse follows the last accepted pair.

Top module: `blit_addr_gen`

## Requirements
- R1: After reset the source stride reads 0x3FF8, and the destination stride, both bases, both linear registers and the control word read 0. busy, addr_valid and done are low.
- R2: Both strides are 14-bit unsigned fields. On write, bits above 13 are dropped and bits 2:0 are forced to zero, so a read returns the written value ANDed with 0x3FF8.
- R3: A write to the destination X/Y word (select 7: X in bits 15:0, Y in bits 31:16) loads the destination linear register with Y*dst_stride + (X << s) + dst_base. The source X/Y word (select 6) does the same for the source side. Here s is 0, 1 or 2 for the depth field in control bits 2:1 (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). Control bit 0 selects backward traversal.
- R4: A direct write to a linear register (select 4 source, 5 destination) clears the low s address bits, so the stored address is pixel aligned.
- R5: A forward blit of W x H pixels presents, for pixel (r, c) in row-major order, src = src_lin + r*src_stride + c*bpp. The destination address follows the same rule with the destination registers.
- R6: A backward blit presents the same addresses in exactly reversed order, starting at row H-1, column W-1.
- R7: While addr_valid is high and addr_ready is low, addr_valid stays high and both addresses stay stable.
- R8: done is high for exactly the one cycle after the last pair is accepted. In that cycle busy and addr_valid are already low.
- R9: Register writes made while busy is high are ignored. A blit never changes any register.
- R10: When a register write and an accepted start fall in the same cycle, the blit uses the values from before the write, and the write takes effect.
- R11: All address arithmetic wraps modulo 2^32.
- R12: A start with zero width or zero height presents no address and gives a done pulse in the next cycle.
- Register selects: 0 src stride, 1 dst stride, 2 src base, 3 dst base, 4 src linear, 5 dst linear, 6 src X/Y, 7 dst X/Y, 8 control. The X/Y selects read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_sel |
| blit_start | input | 1 | Start a blit |
| blit_w | input | 16 | Width in pixels |
| blit_h | input | 16 | Height in pixels |
| busy | output | 1 | Blit in progress |
| addr_valid | output | 1 | Address pair valid |
| addr_ready | input | 1 | Consumer accepts the pair |
| src_addr | output | 32 | Source byte address |
| dst_addr | output | 32 | Destination byte address |
| done | output | 1 | One-cycle end-of-blit pulse |

## Verification
A register write can land in the same cycle that a blit is launched, so the register update and the snapshot taken for the blit compete. The bench raises blit_start together with a stride write. It then compares every address of the run against the old stride and reads the new stride back after done. A second case puts a write in the middle of a stalled blit and confirms that both the addresses and the register read-back ignore it.

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
  parameter int AW = 32,
  parameter int SW = 14,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          blit_start,
  input  logic [CW-1:0] blit_w,
  input  logic [CW-1:0] blit_h,
  output logic          busy,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          done
);
  localparam logic [SW-1:0] SSTR_RST = {{(SW-3){1'b1}}, 3'b000};
  localparam logic [SW-1:0] SMASK    = {{(SW-3){1'b1}}, 3'b000};

  logic [SW-1:0] sstr, dstr;
  logic [AW-1:0] sbase, dbase, slin, dlin;
  logic          back;
  logic [1:0]    depth;

  logic [AW-1:0] s_cur, d_cur, s_row, d_row, s_step, d_step, p_step;
  logic          run_back;
  logic [CW-1:0] col, row, wlast, hlast;

  logic [1:0] sh;
  assign sh = depth[1] ? 2'd2 : {1'b0, depth[0]};

  logic          wr_ok;
  assign wr_ok = reg_wr && !busy;

  logic [CW-1:0] wx, wy;
  assign wx = reg_wdata[CW-1:0];
  assign wy = reg_wdata[2*CW-1:CW];

  logic [AW-1:0] amask, s_xy, d_xy;
  assign amask = ~((AW'(1) << sh) - AW'(1));
  assign s_xy  = AW'(wy) * AW'(sstr) + (AW'(wx) << sh) + sbase;
  assign d_xy  = AW'(wy) * AW'(dstr) + (AW'(wx) << sh) + dbase;

  logic          go, zero_dim, last_col, last_row, fire;
  logic [AW-1:0] s_first, d_first, x_off, s_nrow, d_nrow;
  assign zero_dim = (blit_w == '0) || (blit_h == '0);
  assign go       = blit_start && !busy;
  assign x_off    = AW'(blit_w - CW'(1)) << sh;
  assign s_first  = back ? slin + AW'(blit_h - CW'(1)) * AW'(sstr) + x_off : slin;
  assign d_first  = back ? dlin + AW'(blit_h - CW'(1)) * AW'(dstr) + x_off : dlin;
  assign fire     = busy && addr_ready;
  assign last_col = (col == wlast);
  assign last_row = (row == hlast);
  assign s_nrow   = run_back ? s_row - s_step : s_row + s_step;
  assign d_nrow   = run_back ? d_row - d_step : d_row + d_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sstr  <= SSTR_RST;
      dstr  <= '0;
      sbase <= '0;
      dbase <= '0;
      slin  <= '0;
      dlin  <= '0;
      back  <= 1'b0;
      depth <= 2'd0;
    end else if (wr_ok) begin
      case (reg_sel)
        4'd0: sstr  <= reg_wdata[SW-1:0] & SMASK;
        4'd1: dstr  <= reg_wdata[SW-1:0] & SMASK;
        4'd2: sbase <= reg_wdata[AW-1:0];
        4'd3: dbase <= reg_wdata[AW-1:0];
        4'd4: slin  <= reg_wdata[AW-1:0] & amask;
        4'd5: dlin  <= reg_wdata[AW-1:0] & amask;
        4'd6: slin  <= s_xy;
        4'd7: dlin  <= d_xy;
        4'd8: begin
          back  <= reg_wdata[0];
          depth <= reg_wdata[2:1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      run_back <= 1'b0;
      s_cur    <= '0;
      d_cur    <= '0;
      s_row    <= '0;
      d_row    <= '0;
      s_step   <= '0;
      d_step   <= '0;
      p_step   <= '0;
      col      <= '0;
      row      <= '0;
      wlast    <= '0;
      hlast    <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        if (zero_dim) begin
          done <= 1'b1;
        end else begin
          busy     <= 1'b1;
          run_back <= back;
          s_step   <= AW'(sstr);
          d_step   <= AW'(dstr);
          p_step   <= AW'(1) << sh;
          col      <= '0;
          row      <= '0;
          wlast    <= blit_w - CW'(1);
          hlast    <= blit_h - CW'(1);
          s_cur    <= s_first;
          s_row    <= s_first;
          d_cur    <= d_first;
          d_row    <= d_first;
        end
      end else if (fire) begin
        if (last_col) begin
          if (last_row) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            row   <= row + CW'(1);
            col   <= '0;
            s_row <= s_nrow;
            s_cur <= s_nrow;
            d_row <= d_nrow;
            d_cur <= d_nrow;
          end
        end else begin
          col   <= col + CW'(1);
          s_cur <= run_back ? s_cur - p_step : s_cur + p_step;
          d_cur <= run_back ? d_cur - p_step : d_cur + p_step;
        end
      end
    end
  end

  assign addr_valid = busy;
  assign src_addr   = s_cur;
  assign dst_addr   = d_cur;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      4'd0: reg_rdata = 32'(sstr);
      4'd1: reg_rdata = 32'(dstr);
      4'd2: reg_rdata = 32'(sbase);
      4'd3: reg_rdata = 32'(dbase);
      4'd4: reg_rdata = 32'(slin);
      4'd5: reg_rdata = 32'(dlin);
      4'd8: reg_rdata = {29'd0, depth, back};
      default: reg_rdata = '0;
    endcase
  end

  // R7
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(src_addr) && $stable(dst_addr));

  // R9
  stride_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sstr) && $stable(dstr) && $stable(slin) && $stable(dlin));

  // R8
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid && !busy);
endmodule

// File: tb/sim_blit_addr_gen.sv
module sim_blit_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        blit_start = 1'b0;
  logic [15:0] blit_w = '0;
  logic [15:0] blit_h = '0;
  logic        busy, addr_valid, done;
  logic        addr_ready = 1'b0;
  logic [31:0] src_addr, dst_addr;

  int vecs = 0;
  int errs = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  blit_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blit_start(blit_start),
    .blit_w(blit_w), .blit_h(blit_h), .busy(busy), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .src_addr(src_addr), .dst_addr(dst_addr), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_blit(input string tag, input int w, input int h, input bit stall,
                          input logic [31:0] slin, input logic [31:0] dlin,
                          input logic [31:0] sstr, input logic [31:0] dstr,
                          input int bpp, input bit bk, input bit wr_now,
                          input logic [3:0] wsel, input logic [31:0] wdat);
    int idx = 0;
    int cyc = 0;
    @(negedge clk);
    blit_w = 16'(w); blit_h = 16'(h); blit_start = 1'b1;
    if (wr_now) begin
      reg_wr = 1'b1; reg_sel = wsel; reg_wdata = wdat;
    end
    @(negedge clk);
    blit_start = 1'b0; reg_wr = 1'b0;
    while (idx < w*h && cyc < 2000) begin
      int r, c;
      logic [31:0] es, ed;
      addr_ready = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      r = idx / w; c = idx % w;
      if (bk) begin r = h-1-r; c = w-1-c; end
      es = slin + 32'(r) * sstr + 32'(c * bpp);
      ed = dlin + 32'(r) * dstr + 32'(c * bpp);
      chk({tag, " valid"}, {31'd0, addr_valid}, 32'd1);
      chk({tag, " src"}, src_addr, es);
      chk({tag, " dst"}, dst_addr, ed);
      if (addr_ready) idx++;
      @(negedge clk);
      cyc++;
    end
    addr_ready = 1'b0;
    #1;
    chk({tag, " R8 done"}, {31'd0, done}, 32'd1);
    chk({tag, " R8 valid low"}, {30'd0, addr_valid, busy}, 32'd0);
    @(negedge clk);
    #1;
    chk({tag, " R8 done width"}, {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd0, d); chk("R1 src stride", d, 32'h3FF8);
    for (int s = 1; s <= 5; s++) begin
      rd(4'(s), d); chk("R1 reg zero", d, 32'd0);
    end
    rd(4'd8, d); chk("R1 ctrl", d, 32'd0);
    chk("R1 outputs", {29'd0, busy, addr_valid, done}, 32'd0);
  endtask

  task automatic t_stride_mask();
    logic [31:0] d;
    wr(4'd0, 32'h0000_3FFF); rd(4'd0, d); chk("R2 src stride", d, 32'h3FF8);
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, d); chk("R2 dst stride", d, 32'h3FF8);
    wr(4'd1, 32'h0000_0145); rd(4'd1, d); chk("R2 dst stride low", d, 32'h0140);
  endtask

  task automatic t_xy();
    logic [31:0] d;
    wr(4'd8, 32'd2);
    wr(4'd1, 32'h140);
    wr(4'd3, 32'h1000);
    wr(4'd7, {16'd3, 16'd5});
    rd(4'd5, d); chk("R3 dst xy", d, 32'd3 * 32'h140 + 32'd10 + 32'h1000);
    wr(4'd0, 32'h200);
    wr(4'd2, 32'h8000_0000);
    wr(4'd8, 32'd4);
    wr(4'd6, {16'd7, 16'd9});
    rd(4'd4, d); chk("R3 src xy", d, 32'd7 * 32'h200 + 32'd36 + 32'h8000_0000);
    rd(4'd7, d); chk("R3 xy reads zero", d, 32'd0);
  endtask

  task automatic t_align();
    logic [31:0] d;
    wr(4'd8, 32'd4);
    wr(4'd5, 32'h1237); rd(4'd5, d); chk("R4 align 4B", d, 32'h1234);
    wr(4'd8, 32'd2);
    wr(4'd4, 32'h0F03); rd(4'd4, d); chk("R4 align 2B", d, 32'h0F02);
  endtask

  task automatic t_forward();
    wr(4'd8, 32'd4);
    wr(4'd0, 32'h100); wr(4'd1, 32'h80);
    wr(4'd4, 32'h2000); wr(4'd5, 32'h9000);
    run_blit("R5 fwd", 3, 2, 1'b0, 32'h2000, 32'h9000, 32'h100, 32'h80, 4, 1'b0,
             1'b0, 4'd0, 32'd0);
  endtask

  task automatic t_backward();
    wr(4'd8, 32'd3);
    wr(4'd0, 32'h40); wr(4'd1, 32'h88);
    wr(4'd4, 32'h400); wr(4'd5, 32'h7000);
    run_blit("R6 R7 back stall", 3, 3, 1'b1, 32'h400, 32'h7000, 32'h40, 32'h88, 2, 1'b1,
             1'b0, 4'd0, 32'd0);
  endtask

  task automatic t_busy_write();
    logic [31:0] d;
    wr(4'd8, 32'd4);
    wr(4'd0, 32'h100); wr(4'd4, 32'h3000);
    @(negedge clk);
    blit_w = 16'd4; blit_h = 16'd1; blit_start = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    blit_start = 1'b0;
    reg_wr = 1'b1; reg_sel = 4'd0; reg_wdata = 32'h40;
    @(negedge clk);
    reg_sel = 4'd4; reg_wdata = 32'h5000;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    chk("R9 src during busy", src_addr, 32'h3000);
    addr_ready = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    addr_ready = 1'b0;
    #1;
    chk("R9 done", {31'd0, done}, 32'd1);
    rd(4'd0, d); chk("R9 stride kept", d, 32'h100);
    rd(4'd4, d); chk("R9 linear kept", d, 32'h3000);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(4'd8, 32'd0);
    wr(4'd0, 32'h20); wr(4'd1, 32'h30);
    wr(4'd4, 32'h100); wr(4'd5, 32'h200);
    run_blit("R10 start+write", 2, 2, 1'b0, 32'h100, 32'h200, 32'h20, 32'h30, 1, 1'b0,
             1'b1, 4'd0, 32'h1000);
    rd(4'd0, d); chk("R10 write applied", d, 32'h1000);
  endtask

  task automatic t_wrap();
    wr(4'd8, 32'd4);
    wr(4'd0, 32'h8); wr(4'd1, 32'h8);
    wr(4'd4, 32'hFFFF_FFFC); wr(4'd5, 32'hFFFF_FFF8);
    run_blit("R11 wrap", 3, 2, 1'b0, 32'hFFFF_FFFC, 32'hFFFF_FFF8, 32'h8, 32'h8, 4, 1'b0,
             1'b0, 4'd0, 32'd0);
  endtask

  task automatic t_zero();
    @(negedge clk);
    blit_w = 16'd0; blit_h = 16'd5; blit_start = 1'b1;
    @(negedge clk);
    blit_start = 1'b0;
    #1;
    chk("R12 zero done", {31'd0, done}, 32'd1);
    chk("R12 zero no valid", {31'd0, addr_valid}, 32'd0);
    @(negedge clk);
    #1;
    chk("R12 zero idle", {30'd0, done, addr_valid}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stride_mask();
    t_xy();
    t_align();
    t_forward();
    t_backward();
    t_busy_write();
    t_same_cycle();
    t_wrap();
    t_zero();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule